// File: doc/BRIEF.md
# Ethernet Receive Frame Admission Filter

This block sits behind a receive MAC and decides, once per frame, whether the frame goes on to the host or is thrown away. When the MAC finishes a frame it raises a one-cycle end-of-frame strobe and presents the frame's byte count, its three error flags (CRC, alignment, code) and whether the frame is a MAC control frame and, if so, a pause frame. The filter classifies the frame by length and error state and applies three software enables: keep control frames, keep short frames, keep errored frames.

One clock after the strobe it pulses a valid flag with the forward/drop decision and the descriptor status bits: control, fragment, undersized and the three error bits. Pause handling is reported on a separate pulse for the flow-control logic. That pulse depends only on the pause frame being clean and flow control allowing it. It does not depend on whether the frame is forwarded.

The sequencing is a two-state machine. `S_IDLE` means no report is on the outputs. `S_REPORT` means a decision is presented for exactly one cycle. The transition `T_CAPTURE` (any state to `S_REPORT`) is taken on every strobe, so back-to-back strobes give back-to-back reports. The transition `T_RELEASE` (`S_REPORT` to `S_IDLE`) is taken when no strobe arrives. With every enable at 0, which is the reset value, only clean frames of 64 bytes or more that are not control frames are forwarded.

Top module: `rx_admit_filter`

## Requirements
- R1: For every cycle with `eof_strobe` high, `dec_valid` is high in the following cycle and only then; a cycle without a strobe is followed by `dec_valid` low.
- R2: A frame whose `frame_len` is below 33 is dropped (`dec_forward` = 0) under every enable setting.
- R3: A frame of 33 to 63 bytes with no error flag is reported with `st_undersized` = 1 and `st_fragment` = 0, and is forwarded only when `copy_short_en` is 1 (other rules permitting).
- R4: A frame shorter than 64 bytes with any error flag is reported with `st_fragment` = 1 and `st_undersized` = 0, and is forwarded only when both `copy_short_en` and `copy_err_en` are 1.
- R5: A frame of 64 bytes or more with any error flag is forwarded only when `copy_err_en` is 1; `st_crc_err`, `st_align_err` and `st_code_err` repeat the frame's `err_crc`, `err_align` and `err_code` flags.
- R6: A frame with `is_ctrl` = 1 is forwarded only when `copy_ctrl_en` is 1, and is reported with `st_ctrl` = 1.
- R7: `pause_act` pulses together with `dec_valid` exactly when the frame had `is_ctrl`, `is_pause` and `pause_honor_en` all 1 and no error flag, whatever `dec_forward` is.
- R8: After reset all outputs are 0, and with all three copy enables at 0 a clean frame of 64 bytes or more with `is_ctrl` = 0 is forwarded.
- R9: While `dec_valid` is 0, `dec_forward`, `pause_act` and all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eof_strobe | input | 1 | One-cycle end-of-frame strobe from the MAC |
| frame_len | input | LEN_W | Frame byte count |
| err_crc | input | 1 | Frame had a CRC error |
| err_align | input | 1 | Frame had an alignment error |
| err_code | input | 1 | Frame had a line code error |
| is_ctrl | input | 1 | Frame is a MAC control frame |
| is_pause | input | 1 | Control frame is a pause frame |
| copy_ctrl_en | input | 1 | Forward control frames |
| copy_short_en | input | 1 | Forward frames shorter than 64 bytes (33 or more) |
| copy_err_en | input | 1 | Forward errored frames |
| pause_honor_en | input | 1 | Flow control accepts received pause frames |
| dec_valid | output | 1 | Decision valid pulse |
| dec_forward | output | 1 | 1 forward to host, 0 drop |
| st_ctrl | output | 1 | Status: control frame |
| st_fragment | output | 1 | Status: short frame with error |
| st_undersized | output | 1 | Status: short frame without error |
| st_crc_err | output | 1 | Status: CRC error |
| st_align_err | output | 1 | Status: alignment error |
| st_code_err | output | 1 | Status: code error |
| pause_act | output | 1 | Pause action pulse to flow control |

## Verification
The bench aims at the length edges 32/33 and 63/64. A filter with an off-by-one floor lets a 32-byte frame through, and a wrong short limit tags a 64-byte frame as undersized. It also drives fragments with only one of the two enables set. A design that checks the short-frame enable alone forwards them wrongly. Errored and control pause frames are sent with forwarding disabled, which catches a design that gates the pause pulse with the forward decision. Back-to-back strobes catch a state machine that drops into idle between reports and loses a frame.

// File: rtl/rx_admit_pkg.sv
package rx_admit_pkg;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } admit_state_t;

    typedef struct packed {
        logic is_runt;
        logic is_short;
        logic any_err;
    } frame_class_t;

    typedef struct packed {
        logic ctrl;
        logic fragment;
        logic undersized;
        logic crc_err;
        logic align_err;
        logic code_err;
    } rx_status_t;

    typedef struct packed {
        logic       forward;
        logic       pause;
        rx_status_t status;
    } admit_result_t;

endpackage

// File: rtl/rx_frame_classify.sv
module rx_frame_classify
    import rx_admit_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int SHORT_LIM = 64,
    parameter int FLOOR_LIM = 33
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic             err_crc,
    input  logic             err_align,
    input  logic             err_code,
    output frame_class_t     fclass
);

    localparam logic [LEN_W-1:0] ShortLim = LEN_W'(SHORT_LIM);
    localparam logic [LEN_W-1:0] FloorLim = LEN_W'(FLOOR_LIM);

    always_comb begin
        fclass.is_runt  = (frame_len < FloorLim);
        fclass.is_short = (frame_len < ShortLim);
        fclass.any_err  = err_crc | err_align | err_code;
    end

endmodule

// File: rtl/rx_admit_policy.sv
module rx_admit_policy
    import rx_admit_pkg::*;
(
    input  frame_class_t  fclass,
    input  logic          err_crc,
    input  logic          err_align,
    input  logic          err_code,
    input  logic          is_ctrl,
    input  logic          is_pause,
    input  logic          copy_ctrl_en,
    input  logic          copy_short_en,
    input  logic          copy_err_en,
    input  logic          pause_honor_en,
    output admit_result_t result
);

    logic len_ok;
    logic err_ok;
    logic ctrl_ok;

    always_comb begin
        len_ok  = !fclass.is_runt && (!fclass.is_short || copy_short_en);
        err_ok  = !fclass.any_err || copy_err_en;
        ctrl_ok = !is_ctrl || copy_ctrl_en;

        result.forward           = len_ok && err_ok && ctrl_ok;
        result.pause             = is_ctrl && is_pause && pause_honor_en && !fclass.any_err;
        result.status.ctrl       = is_ctrl;
        result.status.fragment   = fclass.is_short && fclass.any_err;
        result.status.undersized = fclass.is_short && !fclass.any_err;
        result.status.crc_err    = err_crc;
        result.status.align_err  = err_align;
        result.status.code_err   = err_code;
    end

endmodule

// File: rtl/rx_admit_hold.sv
module rx_admit_hold
    import rx_admit_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  admit_result_t din,
    output admit_result_t dout
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/rx_admit_filter.sv
module rx_admit_filter
    import rx_admit_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int SHORT_LIM = 64,
    parameter int FLOOR_LIM = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof_strobe,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             err_crc,
    input  logic             err_align,
    input  logic             err_code,
    input  logic             is_ctrl,
    input  logic             is_pause,
    input  logic             copy_ctrl_en,
    input  logic             copy_short_en,
    input  logic             copy_err_en,
    input  logic             pause_honor_en,
    output logic             dec_valid,
    output logic             dec_forward,
    output logic             st_ctrl,
    output logic             st_fragment,
    output logic             st_undersized,
    output logic             st_crc_err,
    output logic             st_align_err,
    output logic             st_code_err,
    output logic             pause_act
);

    admit_state_t  state_q;
    admit_state_t  state_d;
    frame_class_t  fclass;
    admit_result_t result_now;
    admit_result_t result_held;

    rx_frame_classify #(
        .LEN_W    (LEN_W),
        .SHORT_LIM(SHORT_LIM),
        .FLOOR_LIM(FLOOR_LIM)
    ) u_classify (
        .frame_len(frame_len),
        .err_crc  (err_crc),
        .err_align(err_align),
        .err_code (err_code),
        .fclass   (fclass)
    );

    rx_admit_policy u_policy (
        .fclass        (fclass),
        .err_crc       (err_crc),
        .err_align     (err_align),
        .err_code      (err_code),
        .is_ctrl       (is_ctrl),
        .is_pause      (is_pause),
        .copy_ctrl_en  (copy_ctrl_en),
        .copy_short_en (copy_short_en),
        .copy_err_en   (copy_err_en),
        .pause_honor_en(pause_honor_en),
        .result        (result_now)
    );

    rx_admit_hold u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (eof_strobe),
        .din  (result_now),
        .dout (result_held)
    );

    // Next-state: T_CAPTURE on strobe, T_RELEASE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = eof_strobe ? S_REPORT : S_IDLE;
            S_REPORT: state_d = eof_strobe ? S_REPORT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: presented only while reporting
    always_comb begin
        dec_valid     = 1'b0;
        dec_forward   = 1'b0;
        pause_act     = 1'b0;
        st_ctrl       = 1'b0;
        st_fragment   = 1'b0;
        st_undersized = 1'b0;
        st_crc_err    = 1'b0;
        st_align_err  = 1'b0;
        st_code_err   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
            end
            S_REPORT: begin
                dec_valid     = 1'b1;
                dec_forward   = result_held.forward;
                pause_act     = result_held.pause;
                st_ctrl       = result_held.status.ctrl;
                st_fragment   = result_held.status.fragment;
                st_undersized = result_held.status.undersized;
                st_crc_err    = result_held.status.crc_err;
                st_align_err  = result_held.status.align_err;
                st_code_err   = result_held.status.code_err;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/rx_admit_filter_chk.sv
module rx_admit_filter_chk #(
    parameter int LEN_W     = 16,
    parameter int SHORT_LIM = 64,
    parameter int FLOOR_LIM = 33
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eof_strobe,
    input logic [LEN_W-1:0] frame_len,
    input logic             err_crc,
    input logic             err_align,
    input logic             err_code,
    input logic             is_ctrl,
    input logic             is_pause,
    input logic             copy_ctrl_en,
    input logic             copy_short_en,
    input logic             copy_err_en,
    input logic             pause_honor_en,
    input logic             dec_valid,
    input logic             dec_forward,
    input logic             st_fragment,
    input logic             st_undersized,
    input logic             pause_act
);

    localparam logic [LEN_W-1:0] ShortLim = LEN_W'(SHORT_LIM);
    localparam logic [LEN_W-1:0] FloorLim = LEN_W'(FLOOR_LIM);

    logic any_err;
    assign any_err = err_crc | err_align | err_code;

    a_r1_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        eof_strobe |=> dec_valid);

    a_r1_no_valid_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_strobe |=> !dec_valid);

    a_r2_floor_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_strobe && frame_len < FloorLim) |=> !dec_forward);

    a_r4_fragment_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_strobe && frame_len < ShortLim && any_err && !(copy_short_en && copy_err_en))
        |=> (!dec_forward && st_fragment && !st_undersized));

    a_r6_ctrl_dropped_by_default: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_strobe && is_ctrl && !copy_ctrl_en) |=> !dec_forward);

    a_r7_pause_acted: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_strobe && is_ctrl && is_pause && pause_honor_en && !any_err) |=> pause_act);

    a_r9_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_forward && !pause_act && !st_fragment && !st_undersized));

endmodule

bind rx_admit_filter rx_admit_filter_chk #(
    .LEN_W    (LEN_W),
    .SHORT_LIM(SHORT_LIM),
    .FLOOR_LIM(FLOOR_LIM)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eof_strobe    (eof_strobe),
    .frame_len     (frame_len),
    .err_crc       (err_crc),
    .err_align     (err_align),
    .err_code      (err_code),
    .is_ctrl       (is_ctrl),
    .is_pause      (is_pause),
    .copy_ctrl_en  (copy_ctrl_en),
    .copy_short_en (copy_short_en),
    .copy_err_en   (copy_err_en),
    .pause_honor_en(pause_honor_en),
    .dec_valid     (dec_valid),
    .dec_forward   (dec_forward),
    .st_fragment   (st_fragment),
    .st_undersized (st_undersized),
    .pause_act     (pause_act)
);

// File: tb/rx_admit_filter_test.sv
`timescale 1ns/1ps
module rx_admit_filter_test;

    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             eof_strobe = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic             err_crc = 1'b0, err_align = 1'b0, err_code = 1'b0;
    logic             is_ctrl = 1'b0, is_pause = 1'b0;
    logic             copy_ctrl_en = 1'b0, copy_short_en = 1'b0, copy_err_en = 1'b0;
    logic             pause_honor_en = 1'b0;
    logic             dec_valid, dec_forward, st_ctrl, st_fragment, st_undersized;
    logic             st_crc_err, st_align_err, st_code_err, pause_act;

    int errors = 0;
    int checks = 0;
    int seed_dummy;

    always #2 clk = ~clk;

    rx_admit_filter #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .eof_strobe(eof_strobe), .frame_len(frame_len),
        .err_crc(err_crc), .err_align(err_align), .err_code(err_code),
        .is_ctrl(is_ctrl), .is_pause(is_pause), .copy_ctrl_en(copy_ctrl_en),
        .copy_short_en(copy_short_en), .copy_err_en(copy_err_en),
        .pause_honor_en(pause_honor_en), .dec_valid(dec_valid), .dec_forward(dec_forward),
        .st_ctrl(st_ctrl), .st_fragment(st_fragment), .st_undersized(st_undersized),
        .st_crc_err(st_crc_err), .st_align_err(st_align_err), .st_code_err(st_code_err),
        .pause_act(pause_act)
    );

    // {valid, forward, ctrl, fragment, undersized, crc, align, code, pause}
    function automatic logic [8:0] expect_out(input int len, input logic c, input logic a,
                                              input logic d, input logic ct, input logic p,
                                              input logic ce, input logic se, input logic ee,
                                              input logic he);
        logic err, shrt, fwd, pz;
        err  = c | a | d;
        shrt = (len < 64);
        fwd  = 1'b1;
        if (len < 33) fwd = 1'b0;              // R2
        if (shrt && !se) fwd = 1'b0;           // R3 / R4
        if (err && !ee) fwd = 1'b0;            // R4 / R5
        if (ct && !ce) fwd = 1'b0;             // R6
        pz = ct && p && he && !err;            // R7
        return {1'b1, fwd, ct, shrt && err, shrt && !err, c, a, d, pz};
    endfunction

    function automatic string req_of(input int len, input logic err, input logic ct,
                                     input logic p);
        if (ct && p) return "R7";
        if (ct) return "R6";
        if (len < 33) return "R2";
        if (len < 64) return err ? "R4" : "R3";
        if (err) return "R5";
        return "R8";
    endfunction

    function automatic logic [8:0] got_out();
        return {dec_valid, dec_forward, st_ctrl, st_fragment, st_undersized,
                st_crc_err, st_align_err, st_code_err, pause_act};
    endfunction

    task automatic check(input string req, input logic [8:0] exp);
        checks++;
        if (got_out() !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got_out(), exp);
        end
    endtask

    // drive a frame at negedge, check at next negedge; optionally leave a gap
    task automatic send(input int len, input logic c, input logic a, input logic d,
                        input logic ct, input logic p, input logic ce, input logic se,
                        input logic ee, input logic he, input logic gap);
        frame_len = LEN_W'(len);
        err_crc = c; err_align = a; err_code = d;
        is_ctrl = ct; is_pause = p;
        copy_ctrl_en = ce; copy_short_en = se; copy_err_en = ee; pause_honor_en = he;
        eof_strobe = 1'b1;
        @(negedge clk);
        check(req_of(len, c | a | d, ct, p), expect_out(len, c, a, d, ct, p, ce, se, ee, he));
        if (gap) begin
            eof_strobe = 1'b0;
            @(negedge clk);
            check("R1", 9'b0); // R1 / R9: no strobe, quiet outputs
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        seed_dummy = $urandom(32'h5EED_0A11);
        repeat (3) @(negedge clk);
        check("R8", 9'b0);                     // R8 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 9'b0);

        // directed corners
        send(64,   0,0,0, 0,0, 0,0,0, 0, 1);  // R8 good frame forwarded by default
        send(63,   0,0,0, 0,0, 0,0,0, 0, 1);  // R3 undersized dropped
        send(63,   0,0,0, 0,0, 0,1,0, 0, 1);  // R3 undersized forwarded
        send(33,   0,0,0, 0,0, 0,1,0, 0, 1);  // R3 floor edge
        send(32,   0,0,0, 0,0, 1,1,1, 1, 1);  // R2 runt never forwarded
        send(40,   1,0,0, 0,0, 0,1,0, 0, 1);  // R4 short only
        send(40,   0,1,0, 0,0, 0,0,1, 0, 1);  // R4 error only
        send(40,   0,0,1, 0,0, 0,1,1, 0, 1);  // R4 both set
        send(500,  1,0,1, 0,0, 0,0,0, 0, 1);  // R5 dropped
        send(500,  0,1,0, 0,0, 0,0,1, 0, 1);  // R5 forwarded
        send(64,   0,0,0, 1,0, 0,0,0, 0, 1);  // R6 dropped
        send(64,   0,0,0, 1,0, 1,0,0, 0, 1);  // R6 forwarded
        send(64,   0,0,0, 1,1, 0,0,0, 1, 0);  // R7 pause acted, not forwarded
        send(64,   1,0,0, 1,1, 1,0,1, 1, 0);  // R7 errored pause not acted
        send(64,   0,0,0, 1,1, 1,0,0, 0, 1);  // R7 honor off

        // random mix, back-to-back and gapped (R1)
        for (int i = 0; i < 3000; i++) begin
            int len;
            int b;
            b = $urandom_range(0, 5);
            case (b)
                0: len = $urandom_range(0, 32);
                1: len = $urandom_range(31, 34);
                2: len = $urandom_range(62, 65);
                3: len = $urandom_range(33, 63);
                default: len = $urandom_range(64, 1600);
            endcase
            send(len, ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 5) == 0), ($urandom_range(0, 2) == 0),
                 ($urandom_range(0, 1) == 0), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0));
        end
        eof_strobe = 1'b0;
        @(negedge clk);
        check("R1", 9'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule